// File: doc/BRIEF.md
# Run-Length Parity Checker for a Serial Bit Stream

This block watches a serial stream that delivers one bit per accepted beat and groups consecutive equal bits into runs. The rule it enforces depends on the value of the run: a run of zeros is legal only when it holds an odd number of bits, and a run of ones is legal only when it holds an even number of bits. When a bit of the other value arrives, the run before it is over, and the checker judges that run. An illegal run raises the error flag for exactly one cycle.

The stream side is a plain valid-qualified input. The block never applies back-pressure: every beat with `in_valid` high is consumed at the clock edge where it is sampled, so no ready signal exists. Cycles with `in_valid` low are gaps. They neither end nor extend a run. The error flag is a register. The verdict for the bit sampled at one rising edge appears on `err_o` during the clock cycle that follows that edge. A run that is still open is never judged.

Top module: `rlp_checker`

## Requirements
- R1: While `rst` is high and in the cycle after its last high edge, `err_o` is 0.
- R2: The first valid bit after reset opens a run of length one and produces `err_o` = 0, whatever the stream carried before reset.
- R3: When a valid 1 follows a run of zeros of even length, `err_o` is 1 in the cycle after the edge that sampled that 1.
- R4: When a valid 0 follows a run of ones of odd length, `err_o` is 1 in the cycle after the edge that sampled that 0.
- R5: When a valid bit ends a zero run of odd length or a one run of even length, `err_o` is 0 in the following cycle.
- R6: A valid bit equal to the current run's value extends the run and produces `err_o` = 0, so an open run is never flagged.
- R7: An edge with `in_valid` low gives `err_o` = 0 in the next cycle and leaves the run length unchanged, so the run continues across the gap.
- R8: The stream 000011111000001, first bit first with no gaps, yields the flag sequence 000010000100000.
- R9: Each accepted bit has a latency of one edge: the verdict for the bit sampled at edge k is visible between edge k and edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial stream bit |
| err_o | output | 1 | One-cycle flag for a run that just ended with an illegal length |

## Verification
The bench aims at the run boundaries. It checks a zero run of length two ended by a one, a single one ended by a zero, and legal runs of one zero and two ones. A design with the two parity rules swapped would flag exactly the legal cases there. Gaps placed in the middle of a run catch a design that resets the count or flags during a gap. A reset issued right after an even zero run catches a first bit that judges stale state. Long random streams with biased run lengths are compared against a length-counting model, which exposes an off-by-one in the flag timing.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

  // Tracker state: idle, or value of the open run plus its length parity.
  typedef enum logic [2:0] {
    RL_IDLE   = 3'd0,
    RL_Z_ODD  = 3'd1,
    RL_Z_EVEN = 3'd2,
    RL_O_ODD  = 3'd3,
    RL_O_EVEN = 3'd4
  } rl_state_e;

  function automatic logic run_open(input rl_state_e s);
    return (s != RL_IDLE);
  endfunction

  function automatic logic run_value(input rl_state_e s);
    return (s == RL_O_ODD) || (s == RL_O_EVEN);
  endfunction

  function automatic logic run_is_odd(input rl_state_e s);
    return (s == RL_Z_ODD) || (s == RL_O_ODD);
  endfunction

  function automatic rl_state_e make_state(input logic val, input logic odd);
    rl_state_e r;
    case ({val, odd})
      2'b01:   r = RL_Z_ODD;
      2'b00:   r = RL_Z_EVEN;
      2'b11:   r = RL_O_ODD;
      default: r = RL_O_EVEN;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rlp_step.sv
// Next-state logic of the run tracker and description of the run that closes.
module rlp_step
  import rlp_pkg::*;
(
  input  rl_state_e cur_state,
  input  logic      take,
  input  logic      bit_in,
  output rl_state_e nxt_state,
  output logic      run_closed,
  output logic      closed_val,
  output logic      closed_odd
);

  logic same_run;

  always_comb begin
    same_run   = run_open(cur_state) && (run_value(cur_state) == bit_in);
    closed_val = run_value(cur_state);
    closed_odd = run_is_odd(cur_state);
    run_closed = take && run_open(cur_state) && !same_run;
    nxt_state  = cur_state;
    if (take) begin
      if (same_run) begin
        nxt_state = make_state(bit_in, !run_is_odd(cur_state));
      end else begin
        nxt_state = make_state(bit_in, 1'b1);
      end
    end
  end

endmodule

// File: rtl/rlp_judge.sv
// Legality rule for a closed run; the required parity for each value is a parameter.
module rlp_judge #(
  parameter bit ZERO_NEEDS_ODD = 1'b1,
  parameter bit ONE_NEEDS_ODD  = 1'b0
) (
  input  logic run_closed,
  input  logic closed_val,
  input  logic closed_odd,
  output logic illegal
);

  logic want_odd;

  always_comb begin
    want_odd = closed_val ? ONE_NEEDS_ODD : ZERO_NEEDS_ODD;
    illegal  = run_closed && (closed_odd != want_odd);
  end

endmodule

// File: rtl/rlp_checker.sv
module rlp_checker
  import rlp_pkg::*;
#(
  parameter bit ZERO_NEEDS_ODD = 1'b1,
  parameter bit ONE_NEEDS_ODD  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic err_o
);

  rl_state_e state_q;
  rl_state_e state_d;
  logic      closed;
  logic      c_val;
  logic      c_odd;
  logic      bad;

  rlp_step u_step (
    .cur_state (state_q),
    .take      (in_valid),
    .bit_in    (in_bit),
    .nxt_state (state_d),
    .run_closed(closed),
    .closed_val(c_val),
    .closed_odd(c_odd)
  );

  rlp_judge #(
    .ZERO_NEEDS_ODD(ZERO_NEEDS_ODD),
    .ONE_NEEDS_ODD (ONE_NEEDS_ODD)
  ) u_judge (
    .run_closed(closed),
    .closed_val(c_val),
    .closed_odd(c_odd),
    .illegal   (bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RL_IDLE;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_o   <= bad;
    end
  end

endmodule

// File: rtl/rlp_checker_sva.sv
module rlp_checker_sva (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_bit,
  input logic err_o
);

  // Port-level shadow: last accepted bit and whether its run has even length.
  logic have_q;
  logic last_q;
  logic even_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      last_q <= 1'b0;
      even_q <= 1'b0;
    end else if (in_valid) begin
      have_q <= 1'b1;
      last_q <= in_bit;
      even_q <= (have_q && last_q == in_bit) ? !even_q : 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !err_o);

  assert_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !have_q) |=> !err_o);

  assert_zero_even_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_q && !last_q && in_bit && even_q) |=> err_o);

  assert_one_odd_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_q && last_q && !in_bit && !even_q) |=> err_o);

  assert_legal_end_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_q && (last_q != in_bit) && (last_q == even_q)) |=> !err_o);

  assert_open_run_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && have_q && last_q == in_bit) |=> !err_o);

  assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !err_o);

endmodule

bind rlp_checker rlp_checker_sva u_sva (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_bit  (in_bit),
  .err_o   (err_o)
);

// File: tb/rlp_checker_bench.sv
`timescale 1ns/1ps
module rlp_checker_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic in_bit;
  logic err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model keeps a true run length, not a parity state.
  bit m_have;
  bit m_cur;
  int m_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  rlp_checker u_rlp_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .err_o(err_o)
  );

  function automatic bit model_step(input bit v, input bit b);
    bit e;
    e = 1'b0;
    if (v) begin
      if (!m_have) begin
        m_have = 1'b1; m_cur = b; m_len = 1;
      end else if (b == m_cur) begin
        m_len++;
      end else begin
        e = (m_cur == 1'b0) ? (m_len % 2 == 0) : (m_len % 2 == 1);
        m_cur = b; m_len = 1;
      end
    end
    return e;
  endfunction

  task automatic check(input bit exp, input string tag);
    n_checks++;
    if (err_o !== exp) begin
      n_fail++;
      $display("FAIL %s: err_o=%b expected=%b at %0t", tag, err_o, exp, $time);
    end
  endtask

  // Called at a falling edge; drives, passes one rising edge, checks at next falling edge.
  task automatic step(input bit v, input bit b, input string tag);
    bit e;
    in_valid = v; in_bit = b;
    e = model_step(v, b);
    @(posedge clk);
    @(negedge clk);
    check(e, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    m_have = 1'b0; m_cur = 1'b0; m_len = 0;
    @(posedge clk);
    @(negedge clk);
    check(1'b0, "R1 during reset");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [14:0] ex_in;
    logic [14:0] ex_out;
    bit b;
    ex_in  = 15'b000011111000001;
    ex_out = 15'b000010000100000;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    @(negedge clk);
    do_reset();
    check(1'b0, "R1 after reset");

    // R8 directed example, with explicit expected flags
    for (int i = 14; i >= 0; i--) begin
      in_valid = 1'b1; in_bit = ex_in[i];
      void'(model_step(1'b1, ex_in[i]));
      @(posedge clk);
      @(negedge clk);
      check(ex_out[i], "R8 example stream");
    end

    // R3: zero run of two ended by a one
    do_reset();
    step(1, 0, "R2 first bit");
    step(1, 0, "R6 extend zeros");
    step(1, 1, "R3 even zeros");
    // R4: single one ended by zero
    step(1, 0, "R4 odd ones");
    // R5: one zero then two ones then zero: all legal
    step(1, 1, "R5 odd zeros legal");
    step(1, 1, "R6 extend ones");
    step(1, 0, "R5 even ones legal");
    // R7: gap inside a zero run keeps the count
    step(0, 1, "R7 gap quiet");
    step(1, 0, "R7 after gap");
    step(0, 0, "R7 gap quiet");
    step(1, 1, "R7 run spans gap");

    // R2: reset right after an even zero run
    do_reset();
    step(1, 0, "R6 zeros");
    step(1, 0, "R6 zeros");
    do_reset();
    step(1, 1, "R2 first bit after reset");

    // R9: random stream against model
    do_reset();
    b = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      bit v;
      v = ($urandom % 4) != 0;
      if (($urandom % 10) >= 6) b = ~b;
      step(v, b, "R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule